// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block moves one 8-bit companded voice sample in each direction per frame over a strobe-framed serial link. The frame strobe is active high and repeats at 8 kHz. It marks a single 8-bit timeslot, and transmit and receive share that timeslot. Inside the timeslot the port shifts the outgoing byte out on rising edges of the external bit clock and captures incoming bits on falling edges. In both directions the most significant bit comes first. The serial output is modelled as a data bit plus an output enable, and the enable is low whenever the strobe is low.

Two separate mute inputs replace the outgoing or incoming byte with the negative-zero quiet code. The quiet code depends on the companding law: 0x55 when `alaw_sel` is 1 (A-law) and 0x7F when it is 0 (µ-law). A fast bit clock runs the port in synchronous mode, where a byte crosses the port in the same frame. A slow bit clock needs asynchronous mode, selected by `async_mode`, where each direction adds exactly one frame of delay. The bit clock, strobe and serial input are sampled by the system clock, and edges are found by comparing each sample with the one before.

Top module: `strobed_pcm_port`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it is released, `dout_oe` and `rx_valid` are 0.
- R2: `dout_oe` is 1 only while `stb` is 1, and it is 0 in every cycle where `stb` is 0.
- R3: In synchronous mode (`async_mode`=0), the `tx_byte` value present at the start of a timeslot is shifted out on `dout`, most significant bit first. A new bit appears after each rising edge of `bclk` inside the timeslot.
- R4: In synchronous mode, `din` is captured on each falling edge of `bclk` inside the timeslot, most significant bit first. One cycle after `stb` falls, `rx_valid` pulses for exactly one cycle, and `rx_byte` holds the byte received in that same timeslot.
- R5: A timeslot that ends after fewer than 8 falling edges of `bclk` produces no `rx_valid` pulse, and `rx_byte` keeps its value.
- R6: When `mute_tx` is 1 at the start of a timeslot, the transmitted byte is the quiet code: 0x55 if `alaw_sel`=1 and 0x7F if `alaw_sel`=0.
- R7: When `mute_rx` is 1 as a timeslot ends, the delivered `rx_byte` is the quiet code for the current `alaw_sel`.
- R8: In asynchronous mode (`async_mode`=1), each timeslot transmits the `tx_byte` sampled at the start of the previous timeslot. The first timeslot after reset transmits the quiet code.
- R9: In asynchronous mode, the end of a complete timeslot delivers the byte received in the previous complete timeslot. The first complete timeslot after reset gives no `rx_valid` pulse.
- R10: When `stb` and `bclk` rise in the same cycle, the first bit transmitted is still the most significant bit of the timeslot's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | External serial bit clock |
| stb | input | 1 | Active-high frame strobe that marks the timeslot |
| din | input | 1 | Serial receive data |
| alaw_sel | input | 1 | 1 selects A-law, 0 selects µ-law |
| async_mode | input | 1 | 1 selects the one-frame-delay mode for slow bit clocks |
| mute_tx | input | 1 | Forces the transmitted byte to the quiet code |
| mute_rx | input | 1 | Forces the delivered received byte to the quiet code |
| tx_byte | input | 8 | Parallel byte to transmit |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for `dout` (models the tri-state output) |
| rx_byte | output | 8 | Last delivered received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |

## Verification
In some frames the strobe and the first bit-clock rise arrive in the same cycle, so the byte load and the first shift happen together. The bench confirms that the serialised byte still starts with its most significant bit. In the same way, the end of a timeslot is the cycle where the receive mute and the law select are applied to the delivered byte. The bench changes both of these at random from frame to frame and compares the result with a bench model that tracks the one-frame pipelines of asynchronous mode.

// File: rtl/strobed_pcm_port.sv
module strobed_pcm_port #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                stb,
  input  logic                din,
  input  logic                alaw_sel,
  input  logic                async_mode,
  input  logic                mute_tx,
  input  logic                mute_rx,
  input  logic [SAMPLE_W-1:0] tx_byte,
  output logic                dout,
  output logic                dout_oe,
  output logic [SAMPLE_W-1:0] rx_byte,
  output logic                rx_valid
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

  logic bclk_q, stb_q;
  logic [SAMPLE_W-1:0] tx_shift, tx_dly, rx_shift, rx_dly;
  logic tx_have, rx_have;
  logic [CNT_W-1:0] rx_cnt;

  wire bclk_rise = bclk & ~bclk_q;
  wire bclk_fall = ~bclk & bclk_q;
  wire stb_start = stb & ~stb_q;
  wire stb_end   = ~stb & stb_q;

  wire [SAMPLE_W-1:0] quiet   = alaw_sel ? SAMPLE_W'(8'h55) : SAMPLE_W'(8'h7F);
  wire [SAMPLE_W-1:0] tx_pick = async_mode ? (tx_have ? tx_dly : quiet) : tx_byte;
  wire [SAMPLE_W-1:0] tx_load = mute_tx ? quiet : tx_pick;
  wire [SAMPLE_W-1:0] tx_src  = stb_start ? tx_load : tx_shift;
  wire [CNT_W-1:0]    cnt_base = stb_start ? '0 : rx_cnt;
  wire [SAMPLE_W-1:0] rx_out  = async_mode ? rx_dly : rx_shift;

  assign dout_oe = stb & rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      bclk_q <= bclk;
      stb_q  <= stb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= 1'b0;
      tx_shift <= '0;
      tx_dly   <= '0;
      tx_have  <= 1'b0;
    end else begin
      if (stb && bclk_rise) begin
        dout     <= tx_src[SAMPLE_W-1];
        tx_shift <= {tx_src[SAMPLE_W-2:0], 1'b0};
      end else if (stb_start) begin
        tx_shift <= tx_load;
      end
      if (stb_start && async_mode) begin
        tx_dly  <= tx_byte;
        tx_have <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_shift <= '0;
      rx_cnt   <= '0;
      rx_dly   <= '0;
      rx_have  <= 1'b0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (stb && bclk_fall && cnt_base < FULL) begin
        rx_shift <= {rx_shift[SAMPLE_W-2:0], din};
        rx_cnt   <= cnt_base + 1'b1;
      end else if (stb_start) begin
        rx_cnt <= '0;
      end
      if (stb_end && rx_cnt == FULL) begin
        if (!async_mode || rx_have) begin
          rx_valid <= 1'b1;
          rx_byte  <= mute_rx ? quiet : rx_out;
        end
        if (async_mode) begin
          rx_dly  <= rx_shift;
          rx_have <= 1'b1;
        end
      end
    end
  end

  // R4
  rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  rx_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!stb_q && $past(stb_q)));

  // R5
  rx_full_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(rx_cnt) == FULL));

  // R6
  tx_mute_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_start && mute_tx && !bclk_rise) |=> (tx_shift == $past(quiet)));

  // R8
  tx_async_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_start && async_mode && !tx_have && !bclk_rise) |=> (tx_shift == $past(quiet)));

  // R2
  oe_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> stb);
endmodule

// File: tb/sim_strobed_pcm_port.sv
module sim_strobed_pcm_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, stb = 1'b0, din = 1'b0;
  logic alaw_sel = 1'b0, async_mode = 1'b0, mute_tx = 1'b0, mute_rx = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic dout, dout_oe, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [7:0] m_txd, m_rxd, m_rxlast;
  bit m_txh, m_rxh;

  always #10 clk = ~clk;

  strobed_pcm_port u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .stb(stb), .din(din),
    .alaw_sel(alaw_sel), .async_mode(async_mode), .mute_tx(mute_tx),
    .mute_rx(mute_rx), .tx_byte(tx_byte), .dout(dout), .dout_oe(dout_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  function automatic logic [7:0] quiet(input logic al);
    return al ? 8'h55 : 8'h7F;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stb = 1'b0; bclk = 1'b0;
    repeat (3) @(negedge clk);
    check(dout_oe == 1'b0 && rx_valid == 1'b0, "R1", {6'd0, dout_oe, rx_valid}, 8'h00);
    rst_n = 1'b1;
    m_txh = 0; m_rxh = 0; m_rxlast = 8'h00;
    repeat (2) @(negedge clk);
    check(dout_oe == 1'b0 && rx_valid == 1'b0, "R1", {6'd0, dout_oe, rx_valid}, 8'h00);
  endtask

  task automatic frame(input logic [7:0] txb, input logic [7:0] rxb, input int nbits,
                       input bit together, input string treq, input string rreq);
    logic [7:0] exp_tx, got_tx, exp_rx;
    bit exp_v;
    if (async_mode) exp_tx = m_txh ? m_txd : quiet(alaw_sel);
    else exp_tx = txb;
    if (mute_tx) exp_tx = quiet(alaw_sel);
    tx_byte = txb;
    got_tx = 8'h00;
    @(negedge clk);
    stb = 1'b1;
    if (!together) begin
      repeat (2) @(negedge clk);
      check(dout_oe == 1'b1, "R2", {7'd0, dout_oe}, 8'h01);
    end
    for (int i = 0; i < nbits; i++) begin
      bclk = 1'b1;
      repeat (3) @(negedge clk);
      got_tx = {got_tx[6:0], dout};
      bclk = 1'b0;
      din = rxb[7-i];
      repeat (4) @(negedge clk);
    end
    if (nbits == 8) check(got_tx == exp_tx, treq, got_tx, exp_tx);
    if (async_mode) begin m_txd = txb; m_txh = 1; end
    exp_v = 0;
    exp_rx = m_rxlast;
    if (nbits == 8) begin
      if (!async_mode) begin exp_v = 1; exp_rx = rxb; end
      else if (m_rxh) begin exp_v = 1; exp_rx = m_rxd; end
      if (exp_v && mute_rx) exp_rx = quiet(alaw_sel);
      if (async_mode) begin m_rxd = rxb; m_rxh = 1; end
    end
    stb = 1'b0;
    @(posedge clk); #1;
    check(rx_valid == exp_v, rreq, {7'd0, rx_valid}, {7'd0, exp_v});
    check(rx_byte == exp_rx, rreq, rx_byte, exp_rx);
    if (exp_v) m_rxlast = exp_rx;
    @(posedge clk); #1;
    check(rx_valid == 1'b0, "R4", {7'd0, rx_valid}, 8'h00);
    check(dout_oe == 1'b0, "R2", {7'd0, dout_oe}, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // directed: plain sync bytes, both laws, mutes
    frame(8'hA5, 8'h3C, 8, 0, "R3", "R4");
    frame(8'h80, 8'hFF, 8, 0, "R3", "R4");
    mute_tx = 1; alaw_sel = 1;
    frame(8'h12, 8'h01, 8, 0, "R6", "R4");
    alaw_sel = 0;
    frame(8'h12, 8'h01, 8, 0, "R6", "R4");
    mute_tx = 0; mute_rx = 1;
    frame(8'hD5, 8'h2A, 8, 0, "R3", "R7");
    alaw_sel = 1;
    frame(8'hD5, 8'h2A, 8, 0, "R3", "R7");
    mute_rx = 0;
    // short slot discarded
    frame(8'h0F, 8'hF0, 5, 0, "R3", "R5");
    frame(8'h0F, 8'hF0, 0, 0, "R3", "R5");
    // strobe and bit clock rising together
    frame(8'h96, 8'h69, 8, 1, "R10", "R4");
    // random sync frames
    for (int f = 0; f < 40; f++) begin
      alaw_sel = 1'($urandom); mute_tx = ($urandom % 4) == 0; mute_rx = ($urandom % 4) == 0;
      frame(8'($urandom), 8'($urandom), (($urandom % 6) == 0) ? 6 : 8, 1'($urandom),
            mute_tx ? "R6" : "R3", mute_rx ? "R7" : "R4");
    end
    // asynchronous mode
    mute_tx = 0; mute_rx = 0; alaw_sel = 0;
    async_mode = 1;
    do_reset();
    frame(8'h11, 8'h22, 8, 0, "R8", "R9");
    frame(8'h33, 8'h44, 8, 0, "R8", "R9");
    frame(8'h55, 8'h66, 3, 0, "R8", "R5");
    frame(8'h77, 8'h88, 8, 1, "R10", "R9");
    for (int f = 0; f < 40; f++) begin
      alaw_sel = 1'($urandom); mute_tx = ($urandom % 4) == 0; mute_rx = ($urandom % 4) == 0;
      frame(8'($urandom), 8'($urandom), (($urandom % 6) == 0) ? 4 : 8, 1'($urandom),
            mute_tx ? "R6" : "R8", mute_rx ? "R7" : "R9");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule